// File: doc/BRIEF.md
# Glitchless Multi-Output Clock Enable

This block gates a bank of output clocks under a small set of active-low enable pins. A configuration mask ties each pin to any subset of the outputs, and one output may be tied to several pins. For every output the tied pins are combined so that any pin asking for disable wins. An output tied to no pin stays enabled at all times.

Each output starts and stops cleanly. After it becomes enabled, its gated clock waits for the next rising edge of its source, so the first pulse is a full high phase. After it becomes disabled, the high phase in progress runs to its falling edge before the output parks. The parked state is chosen per output: driven low, driven high, or released to high impedance. High impedance is shown as a drive value plus an output-enable bit.

Everything runs in one master clock domain. Each source clock enters as a level that the master clock samples. The enable pins pass through a two-flop synchroniser before use. The block does not synthesise the clocks and does not store the configuration.

Top module: `clk_gate_bank`

## Requirements
- R1: While `rst_n` is low, at every clock edge each output takes its parked value and parked output-enable (see R9), and every output state machine goes to its idle state.
- R2: Each enable pin passes through two master-clock flops. A pin change sampled at edge k reaches the output state machines at edge k+2. The synchroniser resets to the disabled level (1).
- R3: Bit `p*8+o` of `link_mask` ties pin p to output o. An output is requested on only when every tied, synchronised pin is 0. Any tied pin at 1 disables it.
- R4: An output whose column in `link_mask` is all zero is always requested on.
- R5: A newly enabled output waits in an armed state. It starts only at an edge where its source is sampled 1 and the previous sample was 0. Its first gated cycle is high, and no partial high pulse appears.
- R6: An output disabled while running finishes its current high phase. It parks at the first edge where its source is sampled 0. If the source is already 0 when the disable arrives, it parks at that edge.
- R7: An output re-enabled while it is finishing a high phase goes back to running. It shows no gap and no parked value.
- R8: An output disabled while armed returns to idle and shows no pulse.
- R9: `park_mode[2*o+1:2*o]` selects the parked state of output o: 00 drives 0, 01 drives 1, 10 gives `out_oe`=0 with `out_val`=0 (high impedance), and 11 drives 0. A driven park sets `out_oe`=1.
- R10: While running, an output has `out_oe`=1, and `out_val` equals the source level sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_pin_n | input | 3 | Asynchronous active-low enable pins |
| src_clk | input | 8 | Source clock levels, one per output, sampled by `clk` |
| link_mask | input | 24 | Pin-to-output ties, bit p*8+o |
| park_mode | input | 16 | Two-bit parked-state code per output |
| out_val | output | 8 | Gated clock or parked drive value |
| out_oe | output | 8 | Output drive enable, 0 means high impedance |

## Verification
The in-RTL properties assume that `park_mode` and `link_mask` hold still while outputs are gated. They also assume that each source clock stays at each level for at least one master clock cycle, so that every edge is seen by the sampler. The stimulus sets both configuration words during reset and never touches them again. It drives each source as a divided clock whose phases last two or more master cycles. Pin pulses as short as one master cycle are applied to reach the armed-then-disabled and finishing-then-re-enabled paths. These pulses change only asynchronous pins, which the properties treat as unconstrained.

// File: rtl/cge_pkg.sv
// Shared types for the glitchless clock-enable bank.
// Assumes: nothing beyond IEEE 1800-2017 synthesis subset.
package cge_pkg;

    // Per-output gate state.
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } gate_state_t;

    // Parked-state codes; the unlisted code 2'b11 behaves as PARK_LOW.
    localparam logic [1:0] PARK_LOW  = 2'b00;
    localparam logic [1:0] PARK_HIGH = 2'b01;
    localparam logic [1:0] PARK_HIZ  = 2'b10;

endpackage

// File: rtl/pin_sync.sv
// Multi-bit, multi-stage level synchroniser into the master clock domain.
// Does: resamples each asynchronous pin through STAGES flops.
// Assumes: pins are independent levels (no multi-bit coherency needed);
//          reset is synchronous, active low, and loads RST_VAL.
module pin_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    // Flop chain: stage 0 captures the pin, later stages resample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain[s] <= {WIDTH{RST_VAL}};
            end
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/enable_combine.sv
// Pin-to-output enable fabric with disable dominance.
// Does: for each output, requests "on" only when no tied pin reads 1.
// Assumes: pins are already synchronised; mask bit p*N_OUT+o ties pin p
//          to output o; an untied output is always requested on.
module enable_combine #(
    parameter int N_PIN = 3,
    parameter int N_OUT = 8
) (
    input  logic [N_PIN-1:0]       pin_n,
    input  logic [N_PIN*N_OUT-1:0] link_mask,
    output logic [N_OUT-1:0]       want_on
);

    genvar o;
    generate
        for (o = 0; o < N_OUT; o++) begin : g_col
            logic [N_PIN-1:0] veto;
            genvar p;
            for (p = 0; p < N_PIN; p++) begin : g_pin
                // One pin's vote against this output.
                assign veto[p] = link_mask[p*N_OUT + o] & pin_n[p];
            end
            // Any veto turns the output off.
            assign want_on[o] = ~|veto;
        end
    endgenerate

endmodule

// File: rtl/out_gate.sv
// Single-output glitchless gate with configurable parked state.
// Does: starts the gated clock only on a sampled rising edge, stops it only
//       after a high phase ends, and parks per mode otherwise.
// Assumes: src is a level sampled by clk with each phase >= 1 clk cycle;
//          mode is static while running; outputs are registered.
module out_gate
    import cge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want,
    input  logic       src,
    input  logic [1:0] mode,
    output logic       out_val,
    output logic       out_oe
);

    gate_state_t state, state_nx;
    logic        src_q;
    logic        rise, fall;
    logic        park_val, park_oe;
    logic        run_nx, running;

    assign rise     = src & ~src_q;
    assign fall     = ~src & src_q;
    assign park_val = (mode == PARK_HIGH);
    assign park_oe  = (mode != PARK_HIZ);
    assign running  = (state == ST_RUN) || (state == ST_DRAIN);

    // Next-state rule for the start/stop protocol.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (want) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (!want)     state_nx = ST_OFF;
                else if (rise) state_nx = ST_RUN;
            end
            ST_RUN:   if (!want) state_nx = src ? ST_DRAIN : ST_OFF;
            ST_DRAIN: begin
                if (want)      state_nx = ST_RUN;
                else if (fall) state_nx = ST_OFF;
            end
            default:  state_nx = ST_OFF;
        endcase
    end

    assign run_nx = (state_nx == ST_RUN) || (state_nx == ST_DRAIN);

    // State, source history and registered output drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            src_q   <= 1'b0;
            out_val <= park_val;
            out_oe  <= park_oe;
        end else begin
            state   <= state_nx;
            src_q   <= src;
            out_val <= run_nx ? src  : park_val;
            out_oe  <= run_nx ? 1'b1 : park_oe;
        end
    end

    // R5
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> out_val);

    // R6
    stop_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> !src_q);

    // R7
    drain_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && want) |=> (state == ST_RUN));

    // R8
    armed_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !want) |=> (state == ST_OFF));

    // R9
    park_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (out_oe == ($past(mode) != PARK_HIZ)));

    // R10
    run_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> out_oe);

endmodule

// File: rtl/clk_gate_bank.sv
// Top of the glitchless multi-output clock-enable bank.
// Does: synchronises the enable pins, maps them to outputs with disable
//       dominance, and gates each source clock through its own out_gate.
// Assumes: one master clock domain; source clocks arrive as levels
//          sampled by clk; configuration is static while gating.
module clk_gate_bank #(
    parameter int N_PIN       = 3,
    parameter int N_OUT       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PIN-1:0]       en_pin_n,
    input  logic [N_OUT-1:0]       src_clk,
    input  logic [N_PIN*N_OUT-1:0] link_mask,
    input  logic [2*N_OUT-1:0]     park_mode,
    output logic [N_OUT-1:0]       out_val,
    output logic [N_OUT-1:0]       out_oe
);

    localparam int MODE_W = 2;

    logic [N_PIN-1:0] pin_s_n;
    logic [N_OUT-1:0] want_on;

    pin_sync #(
        .WIDTH   (N_PIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (en_pin_n),
        .q_sync  (pin_s_n)
    );

    enable_combine #(
        .N_PIN (N_PIN),
        .N_OUT (N_OUT)
    ) i_comb (
        .pin_n     (pin_s_n),
        .link_mask (link_mask),
        .want_on   (want_on)
    );

    genvar o;
    generate
        for (o = 0; o < N_OUT; o++) begin : g_out
            out_gate i_gate (
                .clk     (clk),
                .rst_n   (rst_n),
                .want    (want_on[o]),
                .src     (src_clk[o]),
                .mode    (park_mode[MODE_W*o +: MODE_W]),
                .out_val (out_val[o]),
                .out_oe  (out_oe[o])
            );
        end
    endgenerate

endmodule

// File: tb/test_clk_gate_bank.sv
module test_clk_gate_bank;

    localparam int NP = 3;
    localparam int NO = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   en_pin_n = '1;
    logic [NO-1:0]   src_clk = '0;
    logic [NP*NO-1:0] link_mask;
    logic [2*NO-1:0] park_mode;
    logic [NO-1:0]   out_val, out_oe;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R1";

    typedef struct packed { logic [NO-1:0] v; logic [NO-1:0] e; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    clk_gate_bank i_clk_gate_bank (
        .clk(clk), .rst_n(rst_n), .en_pin_n(en_pin_n), .src_clk(src_clk),
        .link_mask(link_mask), .park_mode(park_mode),
        .out_val(out_val), .out_oe(out_oe)
    );

    // Reference model, written from the requirements (R1-style tags below).
    logic [NP-1:0] m_s1 = '1, m_s2 = '1;
    int            m_st [NO];
    logic          m_sq [NO];

    // Model step and expectation push (driver side of the scoreboard).
    always @(posedge clk) begin
        exp_t x;
        logic [NO-1:0] want;
        for (int o = 0; o < NO; o++) begin
            logic [1:0] md;
            logic on;
            md = park_mode[2*o +: 2];
            want[o] = 1'b1;
            for (int p = 0; p < NP; p++)
                if (link_mask[p*NO+o] && m_s2[p]) want[o] = 1'b0;   // R3 R4
            if (!rst_n) begin
                m_st[o] = 0; m_sq[o] = 1'b0;                       // R1
            end else begin
                case (m_st[o])
                    0: if (want[o]) m_st[o] = 1;
                    1: if (!want[o]) m_st[o] = 0;                   // R8
                       else if (src_clk[o] && !m_sq[o]) m_st[o] = 2; // R5
                    2: if (!want[o]) m_st[o] = src_clk[o] ? 3 : 0; // R6
                    default: if (want[o]) m_st[o] = 2;              // R7
                             else if (!src_clk[o]) m_st[o] = 0;
                endcase
                m_sq[o] = src_clk[o];
            end
            on = (m_st[o] >= 2);
            x.v[o] = on ? src_clk[o] : (md == 2'b01);               // R9 R10
            x.e[o] = on ? 1'b1 : (md != 2'b10);
        end
        if (!rst_n) begin m_s1 = '1; m_s2 = '1; end                 // R2
        else begin m_s2 = m_s1; m_s1 = en_pin_n; end
        exp_q.push_back(x);
    end

    // Monitor: compare away from the active edge; also the watchdog.
    always @(negedge clk) begin
        cyc++;
        if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            n_chk++;
            if (out_val !== x.v || out_oe !== x.e) begin
                n_fail++;
                $display("FAIL %s cyc %0d val/oe actual %b/%b expected %b/%b",
                         cur_req, cyc, out_val, out_oe, x.v, x.e);
            end
        end
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Source clocks: output o toggles every o+2 master cycles.
    int div [NO];
    always @(negedge clk) begin
        for (int o = 0; o < NO; o++) begin
            div[o]++;
            if (div[o] >= o + 2) begin div[o] = 0; src_clk[o] <= ~src_clk[o]; end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int o = 0; o < NO; o++) div[o] = 0;
        // pin0 -> {0,3,5}, pin1 -> {6}, pin2 -> {1,2,4,5}, out7 untied (R4)
        link_mask = '0;
        link_mask[0*NO+0] = 1'b1; link_mask[0*NO+3] = 1'b1; link_mask[0*NO+5] = 1'b1;
        link_mask[1*NO+6] = 1'b1;
        link_mask[2*NO+1] = 1'b1; link_mask[2*NO+2] = 1'b1;
        link_mask[2*NO+4] = 1'b1; link_mask[2*NO+5] = 1'b1;
        // modes per output 0..7: 00,01,10,11,00,01,10,01 (R9)
        park_mode = {2'b01, 2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00};

        cur_req = "R1";      wait_cyc(6);
        rst_n = 1'b1;
        cur_req = "R9 R4";   wait_cyc(30);
        cur_req = "R2 R5";   en_pin_n[0] = 1'b0; wait_cyc(40);
        cur_req = "R3";      en_pin_n[2] = 1'b0; wait_cyc(40);
        cur_req = "R6";      en_pin_n[0] = 1'b1; wait_cyc(40);
        cur_req = "R10";     en_pin_n[0] = 1'b0; wait_cyc(40);
        // Short pulses of pin1 to hit armed-then-disabled (R8).
        cur_req = "R8";
        for (int k = 0; k < 12; k++) begin
            en_pin_n[1] = 1'b0; wait_cyc(1 + (k % 3));
            en_pin_n[1] = 1'b1; wait_cyc(5 + k);
        end
        // Short disable blips of pin2 while running (R7).
        cur_req = "R7";
        for (int k = 0; k < 16; k++) begin
            en_pin_n[2] = 1'b1; wait_cyc(1 + (k % 2));
            en_pin_n[2] = 1'b0; wait_cyc(7 + k);
        end
        cur_req = "R6";      en_pin_n = '1; wait_cyc(40);
        cur_req = "R1";      rst_n = 1'b0; wait_cyc(4);
        wait_cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule